// File: doc/BRIEF.md
# Security State Monitor Controller

This block keeps the trust level of a chip as a small state machine and reports it through a memory-mapped status word. Software changes the level by writing a 32-bit command word. Single bits in that word raise a software violation, raise a fatal violation, or ask for an advance to the next level. Two further command bits are sticky locks, and each one closes off one backward transition.

The block resets into the check level. Firmware leaves check by advancing toward trusted and secure, or by raising a violation, which drops the chip into a less trusted level. Non-secure and soft-fail can never climb back to trusted. A fatal violation drops the chip to soft-fail from any level.

Register access uses a plain select / write-enable / address / data bus with combinational read data. A build-time parameter chooses whether data on the bus is byte-swapped (big-endian) or passed through unchanged (little-endian).

Top module: `secmon_ctrl`

## Requirements
- R1: After reset the level is check: the status word at byte offset 0x14 reads 0x0000_0900 and the command word at 0x04 reads zero.
- R2: The level is reported in status bits 11:8 with the codes check 0x9, non-secure 0xB, trusted 0xD, secure 0xF and soft-fail 0x3. All other status bits read zero.
- R3: From check, an advance (command bit 0) moves to trusted, and a software violation (command bit 8) moves to non-secure.
- R4: From trusted, an advance moves to secure. From secure, an advance moves to trusted unless the secure-to-trusted lock (command bit 1) is set.
- R5: From soft-fail, an advance moves to non-secure unless the soft-fail lock (command bit 2) is set. In non-secure, advances and software violations leave the level unchanged.
- R6: From trusted, secure or soft-fail, a software violation moves to soft-fail.
- R7: A fatal violation (command bit 9) moves to soft-fail from any level. When one write sets several action bits, fatal outranks violation, and violation outranks advance.
- R8: The lock bits read back at command bits 1 and 2. Once set, a lock stays set until reset, and writing zero does not clear it. A lock written together with an advance already applies to that advance. Action bits 0, 8 and 9 act for one cycle only and read back as zero.
- R9: Writes to any offset other than 0x04 have no effect. Reads of any offset other than 0x04 and 0x14 return zero, and so does the read data while the block is not selected or is being written.
- R10: With the big-endian parameter set, write data and read data are byte-swapped at the bus, so a swapped command has the same effect as the unswapped command has on a little-endian instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data, in bus byte order |
| bus_rdata | output | 32 | Combinational read data, in bus byte order |

## Verification
One command write can carry a fatal violation, a software violation and an advance together, and a lock bit can arrive in the same write as the advance it should block. The bench writes these combined words (0x301, 0x101, 0x003, 0x005) from check, secure and soft-fail. It then reads the status back and compares it with the behavioural model, which applies the fatal > violation > advance ranking and lets a lock take effect at once. A big-endian instance receives the byte-swapped stimulus, and its readback must be the swapped value of the little-endian result.

// File: rtl/secmon_ctrl.sv
module secmon_ctrl #(
  parameter int ADDR_W = 8,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h04,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [3:0] LV_CHECK  = 4'h9;
  localparam logic [3:0] LV_NONSEC = 4'hB;
  localparam logic [3:0] LV_TRUST  = 4'hD;
  localparam logic [3:0] LV_SECURE = 4'hF;
  localparam logic [3:0] LV_SFAIL  = 4'h3;

  localparam int B_ADV = 0, B_LK_ST = 1, B_LK_SF = 2, B_VIOL = 8, B_FATAL = 9;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [31:0] wd;
  logic [31:0] rd_raw;
  logic [3:0]  lvl_q, lvl_d;
  logic        lk_st_q, lk_sf_q;
  logic        lk_st_eff, lk_sf_eff;
  logic        cmd_wr, adv, viol, fatal;
  logic [27:0] unused_wd;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign wd        = swap32(bus_wdata);
      assign bus_rdata = swap32(rd_raw);
    end else begin : g_le
      assign wd        = bus_wdata;
      assign bus_rdata = rd_raw;
    end
  endgenerate

  assign unused_wd = {wd[31:10], wd[7:3], ^wd};

  assign cmd_wr = bus_sel && bus_we && (bus_addr == CMD_OFS);
  assign adv    = cmd_wr && wd[B_ADV];
  assign viol   = cmd_wr && wd[B_VIOL];
  assign fatal  = cmd_wr && wd[B_FATAL];

  assign lk_st_eff = lk_st_q || (cmd_wr && wd[B_LK_ST]);
  assign lk_sf_eff = lk_sf_q || (cmd_wr && wd[B_LK_SF]);

  always_comb begin
    lvl_d = lvl_q;
    if (fatal) begin
      lvl_d = LV_SFAIL;
    end else if (viol) begin
      case (lvl_q)
        LV_CHECK:                      lvl_d = LV_NONSEC;
        LV_TRUST, LV_SECURE, LV_SFAIL: lvl_d = LV_SFAIL;
        default:                       lvl_d = lvl_q;
      endcase
    end else if (adv) begin
      case (lvl_q)
        LV_CHECK:  lvl_d = LV_TRUST;
        LV_TRUST:  lvl_d = LV_SECURE;
        LV_SECURE: lvl_d = lk_st_eff ? LV_SECURE : LV_TRUST;
        LV_SFAIL:  lvl_d = lk_sf_eff ? LV_SFAIL : LV_NONSEC;
        default:   lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LV_CHECK;
      lk_st_q <= 1'b0;
      lk_sf_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      lk_st_q <= lk_st_eff;
      lk_sf_q <= lk_sf_eff;
    end
  end

  always_comb begin
    rd_raw = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == STS_OFS)      rd_raw = {20'd0, lvl_q, 8'd0};
      else if (bus_addr == CMD_OFS) rd_raw = {29'd0, lk_sf_q, lk_st_q, 1'b0};
    end
  end

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LV_CHECK || lvl_q == LV_NONSEC || lvl_q == LV_TRUST ||
     lvl_q == LV_SECURE || lvl_q == LV_SFAIL));

  assert_fatal_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == CMD_OFS && wd[B_FATAL]) |=> (lvl_q == LV_SFAIL));

  assert_nonsec_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LV_NONSEC && !(bus_sel && bus_we && wd[B_FATAL])) |=> (lvl_q == LV_NONSEC));

  assert_lock_st_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_st_q |=> lk_st_q);

  assert_lock_sf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_sf_q |=> lk_sf_q);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == CMD_OFS) |=> $stable(lvl_q));

  assert_sfail_no_trust_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LV_SFAIL) |=> (lvl_q != LV_TRUST));
endmodule

// File: tb/secmon_ctrl_tb_top.sv
module secmon_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_le, rdata_be;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  secmon_ctrl #(.ADDR_W(8), .BIG_ENDIAN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_le));

  secmon_ctrl #(.ADDR_W(8), .BIG_ENDIAN(1'b1)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(sw(bus_wdata)), .bus_rdata(rdata_be));

  // Behavioural reference model
  int m_lvl;
  bit m_lk1, m_lk2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl <= 9; m_lk1 <= 0; m_lk2 <= 0;
    end else if (bus_sel && bus_we && bus_addr == 8'h04) begin
      bit l1, l2;
      l1 = m_lk1 | bus_wdata[1];
      l2 = m_lk2 | bus_wdata[2];
      m_lk1 <= l1; m_lk2 <= l2;
      if (bus_wdata[9]) m_lvl <= 3;
      else if (bus_wdata[8]) begin
        if (m_lvl == 9) m_lvl <= 11;
        else if (m_lvl != 11) m_lvl <= 3;
      end else if (bus_wdata[0]) begin
        if (m_lvl == 9) m_lvl <= 13;
        else if (m_lvl == 13) m_lvl <= 15;
        else if (m_lvl == 15 && !l1) m_lvl <= 13;
        else if (m_lvl == 3 && !l2) m_lvl <= 11;
      end
    end
  end

  function automatic logic [31:0] expect_rd(input logic [7:0] a);
    if (!bus_sel || bus_we) return 32'h0;
    if (a == 8'h14) return 32'(m_lvl) << 8;
    if (a == 8'h04) return {29'd0, m_lk2, m_lk1, 1'b0};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
    chk(tag, rdata_le, expect_rd(a));
    chk({tag, " R10"}, rdata_be, sw(expect_rd(a)));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cmd_then_status(input logic [31:0] d, input string tag);
    wr(8'h04, d);
    rd(8'h14, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    rd(8'h14, "R1 reset status");
    chk("R1 reset level code", rdata_le, 32'h0000_0900);
    rd(8'h04, "R1 reset cmd");

    cmd_then_status(32'h1, "R3 check->trusted");
    chk("R2 trusted code", rdata_le, 32'h0000_0D00);
    cmd_then_status(32'h1, "R4 trusted->secure");
    chk("R2 secure code", rdata_le, 32'h0000_0F00);
    cmd_then_status(32'h1, "R4 secure->trusted");
    cmd_then_status(32'h1, "R4 trusted->secure again");
    cmd_then_status(32'h100, "R6 secure viol->softfail");
    chk("R2 softfail code", rdata_le, 32'h0000_0300);
    cmd_then_status(32'h1, "R5 softfail->nonsec");
    chk("R2 nonsec code", rdata_le, 32'h0000_0B00);
    cmd_then_status(32'h1, "R5 nonsec advance ignored");
    cmd_then_status(32'h100, "R5 nonsec viol ignored");
    cmd_then_status(32'h200, "R7 fatal from nonsec");
    rd(8'h04, "R8 action bits read zero");

    do_reset();
    cmd_then_status(32'h100, "R3 check viol->nonsec");

    do_reset();
    cmd_then_status(32'h1, "R3 to trusted");
    cmd_then_status(32'h100, "R6 trusted viol->softfail");
    cmd_then_status(32'h100, "R6 softfail viol stays");

    do_reset();
    cmd_then_status(32'h301, "R7 fatal outranks all");
    do_reset();
    cmd_then_status(32'h101, "R7 viol outranks advance");

    do_reset();
    cmd_then_status(32'h1, "R3 to trusted");
    cmd_then_status(32'h1, "R4 to secure");
    cmd_then_status(32'h3, "R8 lock same write blocks secure->trusted");
    rd(8'h04, "R8 lock st reads back");
    wr(8'h04, 32'h0);
    rd(8'h04, "R8 zero write keeps lock");
    cmd_then_status(32'h1, "R4 locked secure stays");
    cmd_then_status(32'h100, "R6 secure viol->softfail");
    cmd_then_status(32'h5, "R8 lock same write blocks softfail->nonsec");
    rd(8'h04, "R8 both locks read back");

    wr(8'h14, 32'h100);
    rd(8'h14, "R9 write to status ignored");
    wr(8'h08, 32'h200);
    rd(8'h14, "R9 write to other offset ignored");
    rd(8'h0C, "R9 unmapped read zero");
    @(negedge clk); bus_sel = 1'b0; bus_addr = 8'h14; #1;
    chk("R9 unselected read zero", rdata_le, 32'h0);
    chk("R9 unselected read zero R10", rdata_be, 32'h0);

    do_reset();
    rd(8'h04, "R8 locks cleared by reset");
    rd(8'h14, "R1 status after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule